// File: doc/BRIEF.md
# Programmable Periodic Rate Divider

This block turns a reference-clock enable into the timing events of a real-time clock. A prescaler reduces the reference enable to a common 32768 Hz base tick for three supported reference frequencies (4.194304 MHz, 1.048576 MHz, 32.768 kHz). A 15-bit divider chain counts base ticks and emits a one-second tick each time it wraps. Taps on the same chain give a periodic event and a square wave.

A 4-bit rate code picks the periodic rate from a power-of-two ladder, and code 0 switches the periodic function off. A 3-bit divider-control field selects the reference frequency. The same field can also clear and hold the whole chain, or stop it without clearing it. The periodic event pulses whenever the rate is nonzero. A separate enable gates only the interrupt request derived from it. A square-wave enable gates the square-wave output.

All outputs are registered and change on the rising edge of `clk`. In the 32.768 kHz setting with `ref_en` held high, one base tick occurs per clock cycle.

Top module: `prd_rate_divider`

## Requirements
- R1: While `rst_n` is low and after it is released with the divider held, `sec_tick`, `per_pulse`, `per_irq` and `sqw_out` are all 0.
- R2: `div_ctl` = 3'b000 produces one base tick per 128 reference enables, 3'b001 produces one per 32, and 3'b010 produces one per reference enable. With rate code 3 and `ref_en` high every cycle, `per_pulse` therefore repeats every 512, 128 and 4 clock cycles respectively.
- R3: `div_ctl` = 3'b110 or 3'b111 clears the prescaler and the chain and keeps them cleared. No `sec_tick`, `per_pulse` or `per_irq` occurs, and `sqw_out` is 0.
- R4: `div_ctl` = 3'b011, 3'b100 or 3'b101 stops the chain without clearing it. No events occur, and `sqw_out` keeps its level.
- R5: A rate code c from 3 to 15 gives a `per_pulse` every 2^(c-1) base ticks. Code 1 gives one every 128 base ticks and code 2 gives one every 256 base ticks. Each pulse lasts one cycle.
- R6: Rate code 0 produces no `per_pulse`, no `per_irq`, and a constant-low `sqw_out`.
- R7: `per_pulse` occurs regardless of `per_ie`. `per_irq` pulses together with `per_pulse` only while `per_ie` is 1.
- R8: With `sqw_en` = 1 and a nonzero rate, `sqw_out` is a 50% square wave at the periodic rate, with each level lasting half a period. With `sqw_en` = 0, `sqw_out` is 0.
- R9: `sec_tick` pulses once every 32768 base ticks. The first pulse comes exactly 32768 base ticks after the divider leaves the held state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_en | input | 1 | One-cycle enable per reference-clock period |
| div_ctl | input | 3 | Reference select / chain hold / chain stop |
| rate_sel | input | 4 | Periodic rate code, 0 = off |
| per_ie | input | 1 | Periodic interrupt request enable |
| sqw_en | input | 1 | Square-wave output enable |
| sec_tick | output | 1 | One-cycle pulse once per second |
| per_pulse | output | 1 | One-cycle periodic event |
| per_irq | output | 1 | Periodic event gated by `per_ie` |
| sqw_out | output | 1 | Square-wave level |

## Verification
The bench measures the spacing between periodic pulses for the rate codes at both ends of the ladder and for the two irregular low codes. A wrong shift or a swapped code therefore shows up as a wrong interval. The same rate code is repeated under all three reference settings, which separates the prescaler ratios from the rate taps. The square-wave high time is measured at several rates to catch an off-by-one tap. The first second is counted cycle by cycle from the release of the hold, which pins the chain's starting value. Hold, stop and rate-0 windows confirm that events are absent and that the square-wave level behaves as stated. Counting pulses against interrupt requests under both enable values shows that the enable gates only the request.

// File: rtl/prd_pkg.sv
package prd_pkg;

    typedef enum logic [2:0] {
        MODE_4M,
        MODE_1M,
        MODE_32K,
        MODE_FREEZE,
        MODE_HOLD
    } div_mode_e;

    function automatic div_mode_e decode_div(input logic [2:0] code);
        case (code)
            3'b000:         return MODE_4M;
            3'b001:         return MODE_1M;
            3'b010:         return MODE_32K;
            3'b110, 3'b111: return MODE_HOLD;
            default:        return MODE_FREEZE;
        endcase
    endfunction

    // number of chain bits between two periodic events
    function automatic logic [3:0] rate_shift(input logic [3:0] code);
        case (code)
            4'd0:    return 4'd0;
            4'd1:    return 4'd7;
            4'd2:    return 4'd8;
            default: return code - 4'd1;
        endcase
    endfunction

endpackage

// File: rtl/prd_prescaler.sv
module prd_prescaler
    import prd_pkg::*;
#(
    parameter int PRE_W = 7
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      ref_en,
    input  div_mode_e mode,
    output logic      adv
);
    localparam int SH_W = $clog2(PRE_W + 1);

    typedef struct packed {
        logic [PRE_W-1:0] cnt;
    } pre_state_t;

    pre_state_t       st_d, st_q;
    logic [SH_W-1:0]  sh;
    logic [PRE_W:0]   full_mask;
    logic [PRE_W-1:0] mask;
    logic             running;

    always_comb begin
        st_d    = st_q;
        running = 1'b1;
        sh      = '0;
        case (mode)
            MODE_4M:  sh = SH_W'(PRE_W);
            MODE_1M:  sh = SH_W'(PRE_W - 2);
            MODE_32K: sh = '0;
            default:  running = 1'b0;
        endcase
        full_mask = ({{PRE_W{1'b0}}, 1'b1} << sh) - 1'b1;
        mask      = full_mask[PRE_W-1:0];
        adv       = running && ref_en && ((st_q.cnt & mask) == mask);
        if (mode == MODE_HOLD) begin
            st_d.cnt = '0;
        end else if (running && ref_en) begin
            st_d.cnt = st_q.cnt + PRE_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R3
    hold_clears_pre_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(mode == MODE_HOLD) |-> (st_q.cnt == '0));

endmodule

// File: rtl/prd_chain.sv
module prd_chain #(
    parameter int CHAIN_W = 15
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               hold,
    input  logic               adv,
    output logic [CHAIN_W-1:0] cnt_nx,
    output logic [CHAIN_W-1:0] cnt_q,
    output logic               sec_tick
);
    typedef struct packed {
        logic [CHAIN_W-1:0] cnt;
        logic               sec;
    } chain_state_t;

    chain_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.sec = 1'b0;
        if (hold) begin
            st_d.cnt = '0;
        end else if (adv) begin
            st_d.cnt = st_q.cnt + CHAIN_W'(1);
            st_d.sec = (st_d.cnt == '0);
        end
        cnt_nx = st_d.cnt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_q    = st_q.cnt;
    assign sec_tick = st_q.sec;

    // R3
    hold_clears_chain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(hold) |-> (st_q.cnt == '0 && !st_q.sec));

    // R9
    sec_at_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.sec |-> (st_q.cnt == '0 && $past(st_q.cnt) == {CHAIN_W{1'b1}}));

endmodule

// File: rtl/prd_tap.sv
module prd_tap
    import prd_pkg::*;
#(
    parameter int CHAIN_W = 15
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               adv,
    input  logic [CHAIN_W-1:0] cnt_nx,
    input  logic [3:0]         rate_sel,
    input  logic               per_ie,
    input  logic               sqw_en,
    output logic               per_pulse,
    output logic               per_irq,
    output logic               sqw_out
);
    typedef struct packed {
        logic pulse;
        logic irq;
        logic sqw;
    } tap_state_t;

    tap_state_t         st_d, st_q;
    logic [3:0]         k;
    logic [3:0]         km1;
    logic               active;
    logic [CHAIN_W:0]   full_mask;
    logic [CHAIN_W-1:0] mask;
    logic [CHAIN_W-1:0] shifted;

    always_comb begin
        k         = rate_shift(rate_sel);
        km1       = k - 4'd1;
        active    = (rate_sel != 4'd0);
        full_mask = ({{CHAIN_W{1'b0}}, 1'b1} << k) - 1'b1;
        mask      = full_mask[CHAIN_W-1:0];
        shifted   = cnt_nx >> km1;
        st_d.pulse = active && adv && ((cnt_nx & mask) == '0);
        st_d.irq   = st_d.pulse && per_ie;
        st_d.sqw   = active && sqw_en && shifted[0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign per_pulse = st_q.pulse;
    assign per_irq   = st_q.irq;
    assign sqw_out   = st_q.sqw;

    // R6
    rate_off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rate_sel == 4'd0) |-> (!st_q.pulse && !st_q.sqw));

    // R7
    irq_needs_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.irq |-> (st_q.pulse && $past(per_ie)));

    // R8
    sqw_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(sqw_en) |-> !st_q.sqw);

endmodule

// File: rtl/prd_rate_divider.sv
module prd_rate_divider
    import prd_pkg::*;
#(
    parameter int PRE_W   = 7,
    parameter int CHAIN_W = 15
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ref_en,
    input  logic [2:0] div_ctl,
    input  logic [3:0] rate_sel,
    input  logic       per_ie,
    input  logic       sqw_en,
    output logic       sec_tick,
    output logic       per_pulse,
    output logic       per_irq,
    output logic       sqw_out
);
    div_mode_e          mode;
    logic               adv;
    logic [CHAIN_W-1:0] cnt_nx;
    logic [CHAIN_W-1:0] cnt_q;

    assign mode = decode_div(div_ctl);

    prd_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .ref_en (ref_en),
        .mode   (mode),
        .adv    (adv)
    );

    prd_chain #(.CHAIN_W(CHAIN_W)) u_chain (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold     (mode == MODE_HOLD),
        .adv      (adv),
        .cnt_nx   (cnt_nx),
        .cnt_q    (cnt_q),
        .sec_tick (sec_tick)
    );

    prd_tap #(.CHAIN_W(CHAIN_W)) u_tap (
        .clk       (clk),
        .rst_n     (rst_n),
        .adv       (adv),
        .cnt_nx    (cnt_nx),
        .rate_sel  (rate_sel),
        .per_ie    (per_ie),
        .sqw_en    (sqw_en),
        .per_pulse (per_pulse),
        .per_irq   (per_irq),
        .sqw_out   (sqw_out)
    );

    // R4
    freeze_keeps_chain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(mode == MODE_FREEZE) |-> $stable(cnt_q));

endmodule

// File: tb/prd_rate_divider_tb.sv
module prd_rate_divider_tb;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       ref_en;
    logic [2:0] div_ctl;
    logic [3:0] rate_sel;
    logic       per_ie;
    logic       sqw_en;
    logic       sec_tick;
    logic       per_pulse;
    logic       per_irq;
    logic       sqw_out;

    int n_checks = 0;
    int n_fails  = 0;

    always #5 clk = ~clk;

    prd_rate_divider u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .ref_en    (ref_en),
        .div_ctl   (div_ctl),
        .rate_sel  (rate_sel),
        .per_ie    (per_ie),
        .sqw_en    (sqw_en),
        .sec_tick  (sec_tick),
        .per_pulse (per_pulse),
        .per_irq   (per_irq),
        .sqw_out   (sqw_out)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // cycles from one per_pulse to the next
    task automatic pulse_period(output int cyc);
        int guard = 0;
        cyc = 0;
        do begin @(negedge clk); guard++; end while (!per_pulse && guard < 40000);
        do begin @(negedge clk); cyc++; end while (!per_pulse && cyc < 40000);
    endtask

    // length of one high phase of sqw_out
    task automatic sqw_high(output int cyc);
        int guard = 0;
        cyc = 0;
        do begin @(negedge clk); guard++; end while (sqw_out && guard < 40000);
        do begin @(negedge clk); guard++; end while (!sqw_out && guard < 80000);
        cyc = 1;
        forever begin
            @(negedge clk);
            if (!sqw_out || cyc > 40000) break;
            cyc++;
        end
    endtask

    // count events over a window
    task automatic watch(input int len, output int pulses, output int irqs,
                         output int secs, output int sqw_hi);
        pulses = 0; irqs = 0; secs = 0; sqw_hi = 0;
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            pulses += int'(per_pulse);
            irqs   += int'(per_irq);
            secs   += int'(sec_tick);
            sqw_hi += int'(sqw_out);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0; ref_en = 1'b1; div_ctl = 3'b110; rate_sel = 4'd3;
        per_ie = 1'b1; sqw_en = 1'b1;
        repeat (4) @(negedge clk);
        chk({sec_tick, per_pulse, per_irq, sqw_out} == 4'b0, "R1", "outputs in reset",
            {sec_tick, per_pulse, per_irq, sqw_out}, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk({sec_tick, per_pulse, per_irq, sqw_out} == 4'b0, "R1", "outputs after reset",
            {sec_tick, per_pulse, per_irq, sqw_out}, 0);
    endtask

    task automatic t_first_second();
        int early = 0;
        div_ctl = 3'b110; rate_sel = 4'd0;
        repeat (3) @(negedge clk);
        div_ctl = 3'b010;
        repeat (32767) begin @(negedge clk); early += int'(sec_tick); end
        chk(early == 0, "R9", "sec_tick before one second", early, 0);
        @(negedge clk);
        chk(sec_tick == 1'b1, "R9", "sec_tick at 32768 base ticks", sec_tick, 1);
    endtask

    task automatic t_rates();
        int cyc;
        int codes[6] = '{3, 4, 8, 1, 2, 15};
        int exps[6]  = '{4, 8, 128, 128, 256, 16384};
        div_ctl = 3'b010;
        for (int i = 0; i < 6; i++) begin
            rate_sel = 4'(codes[i]);
            pulse_period(cyc);
            pulse_period(cyc);
            chk(cyc == exps[i], "R5", $sformatf("period for code %0d", codes[i]), cyc, exps[i]);
        end
    endtask

    task automatic t_prescale();
        int cyc;
        rate_sel = 4'd3;
        div_ctl = 3'b000;
        pulse_period(cyc); pulse_period(cyc);
        chk(cyc == 512, "R2", "4.19 MHz reference period", cyc, 512);
        div_ctl = 3'b001;
        pulse_period(cyc); pulse_period(cyc);
        chk(cyc == 128, "R2", "1.05 MHz reference period", cyc, 128);
        div_ctl = 3'b010;
        pulse_period(cyc); pulse_period(cyc);
        chk(cyc == 4, "R2", "32.768 kHz reference period", cyc, 4);
    endtask

    task automatic t_rate_zero();
        int p, q, s, h;
        div_ctl = 3'b010; per_ie = 1'b1; sqw_en = 1'b1; rate_sel = 4'd0;
        @(negedge clk);
        watch(3000, p, q, s, h);
        chk(p == 0 && q == 0, "R6", "events with rate 0", p + q, 0);
        chk(h == 0, "R6", "square-wave high cycles with rate 0", h, 0);
    endtask

    task automatic t_irq_gate();
        int p, q, s, h;
        div_ctl = 3'b010; rate_sel = 4'd3; per_ie = 1'b0;
        repeat (2) @(negedge clk);
        watch(400, p, q, s, h);
        chk(p == 100, "R7", "pulses with enable off", p, 100);
        chk(q == 0, "R7", "requests with enable off", q, 0);
        per_ie = 1'b1;
        @(negedge clk);
        watch(400, p, q, s, h);
        chk(q == p && p == 100, "R7", "requests with enable on", q, 100);
    endtask

    task automatic t_sqw();
        int cyc, p, q, s, h;
        int codes[3] = '{3, 6, 1};
        int exps[3]  = '{2, 16, 64};
        div_ctl = 3'b010; sqw_en = 1'b1;
        for (int i = 0; i < 3; i++) begin
            rate_sel = 4'(codes[i]);
            sqw_high(cyc);
            sqw_high(cyc);
            chk(cyc == exps[i], "R8", $sformatf("high time for code %0d", codes[i]), cyc, exps[i]);
        end
        sqw_en = 1'b0;
        @(negedge clk);
        watch(500, p, q, s, h);
        chk(h == 0, "R8", "square wave when disabled", h, 0);
        sqw_en = 1'b1;
    endtask

    task automatic t_hold();
        int p, q, s, h;
        rate_sel = 4'd3; sqw_en = 1'b1; per_ie = 1'b1;
        for (int c = 6; c <= 7; c++) begin
            div_ctl = 3'(c);
            @(negedge clk);
            watch(1000, p, q, s, h);
            chk(p + q + s == 0, "R3", $sformatf("events with code %0d", c), p + q + s, 0);
            chk(h == 0, "R3", $sformatf("square wave with code %0d", c), h, 0);
        end
    endtask

    task automatic t_freeze();
        int p, q, s, h;
        logic lvl;
        rate_sel = 4'd6; sqw_en = 1'b1; per_ie = 1'b1;
        div_ctl = 3'b010;
        repeat (21) @(negedge clk);
        for (int c = 3; c <= 5; c++) begin
            div_ctl = 3'(c);
            @(negedge clk);
            lvl = sqw_out;
            watch(1000, p, q, s, h);
            chk(p + q + s == 0, "R4", $sformatf("events with code %0d", c), p + q + s, 0);
            chk(h == (lvl ? 1000 : 0), "R4", $sformatf("held level with code %0d", c),
                h, lvl ? 1000 : 0);
        end
        div_ctl = 3'b010;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 190000, 0);
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    initial begin
        t_reset();
        t_first_second();
        t_rates();
        t_prescale();
        t_rate_zero();
        t_irq_gate();
        t_sqw();
        t_hold();
        t_freeze();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

endmodule